// File: doc/BRIEF.md
# Boot Code Source Selector with RAM Shadow Copy

This block decides, once per power-on reset, where the processor core takes its program code from. In the first clock cycle after reset is released it samples a strap input that says whether an external ROM is fitted. If the strap is low, the internal ROM becomes the code space and the core is allowed to run right away. If the strap is high, the internal ROM is locked out. The block then reads the external ROM one byte at a time over a simple request/valid port, stores each byte in an on-chip shadow RAM, and lets the core run from that RAM only after the last byte is stored.

The core fetches code through a byte-wide fetch port with a one-cycle registered latency. The same port serves the RAM copy or the internal ROM, depending on the sampled source. Addresses outside the selected memory read as zero, and every fetch reads zero until the core is released. A new reset at any time, including in the middle of a copy, abandons the current sequence. Boot then starts over with a fresh strap sample.

Top module: `boot_shadow_ctrl`

## Requirements
- R1: The strap is sampled only on the first rising clock edge after reset is released. Later strap changes do not alter `boot_src`, `core_run` or the fetch results.
- R2: With the strap low, `core_run` and `boot_done` are 1 and `boot_src` is 0 after that first edge, and `ext_rd_req` never goes high.
- R3: With the strap high, the block makes exactly 1536 one-cycle request pulses, at addresses 0, 1, ..., 1535 in ascending order. It does not issue the next request until `ext_rd_valid` has returned the byte for the current one.
- R4: `core_run` stays 0 for the whole copy. It is 1 in the cycle right after the clock edge that samples `ext_rd_valid` for address 1535.
- R5: In external mode, a fetch of address A below 1536 returns, one cycle later, the byte the external ROM supplied for A. The internal ROM never reaches `fetch_data`.
- R6: In internal mode, a fetch of address A below 4096 returns, one cycle later, the internal ROM byte A[7:0] XOR {A[11:8],A[11:8]} XOR 8'h5A.
- R7: A fetch address of 1536 or above in external mode, or of 4096 or above in internal mode, returns 8'h00.
- R8: While `core_run` is 0, including during reset and during the copy, `fetch_data` reads 8'h00.
- R9: Once `boot_done` is 1, it stays 1, and `boot_src` keeps its value (0 internal, 1 external) until the next reset.
- R10: A reset during a copy aborts it. The next boot samples the strap afresh, and if the strap is high again, the copy restarts at address 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high power-on reset |
| strap_ext_rom | input | 1 | High when an external ROM is fitted |
| ext_rd_req | output | 1 | One-cycle read request pulse to the external ROM |
| ext_rd_addr | output | 11 | Byte address of the pending external read |
| ext_rd_valid | input | 1 | External ROM presents the requested byte |
| ext_rd_data | input | 8 | Byte returned by the external ROM |
| fetch_addr | input | 13 | Core code-fetch address |
| fetch_data | output | 8 | Code byte, one cycle after the address |
| core_run | output | 1 | Core may execute |
| boot_done | output | 1 | Code memory is ready |
| boot_src | output | 1 | Selected code source: 0 internal ROM, 1 shadow RAM |

## Verification
In internal mode, `core_run`, `boot_done` and `boot_src` settle on the first edge after reset is released, so the bench reads them at the next falling edge. In external mode, `core_run` is checked at the falling edge where the last valid is driven, where it must still be 0. It is checked again one falling edge later, where it must be 1. Each fetch result is due exactly one edge after its address. The fetch driver sets an address at a falling edge and queues the expected byte. The monitor takes one queued entry 2 ns after each following rising edge, so every comparison lands on the cycle the registered output changes. The external ROM model records the address of every request and confirms that no second request appears while it is still answering one.

// File: rtl/boot_pkg.sv
package boot_pkg;

  localparam int BYTE_W = 8;

  typedef enum logic [1:0] {
    ST_SAMPLE,
    ST_ISSUE,
    ST_WAIT,
    ST_RUN
  } boot_st_t;

  // Internal ROM image: computed per address rather than stored as a table.
  function automatic logic [BYTE_W-1:0] rom_pattern(input logic [11:0] a);
    return a[7:0] ^ {a[11:8], a[11:8]} ^ 8'h5A;
  endfunction

endpackage

// File: rtl/boot_copy_seq.sv
module boot_copy_seq
  import boot_pkg::*;
#(
  parameter int RAM_BYTES = 1536,
  parameter int RAM_AW    = $clog2(RAM_BYTES)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              strap,
  output logic              ext_rd_req,
  output logic [RAM_AW-1:0] ext_rd_addr,
  input  logic              ext_rd_valid,
  input  logic [BYTE_W-1:0] ext_rd_data,
  output logic              wr_en,
  output logic [RAM_AW-1:0] wr_addr,
  output logic [BYTE_W-1:0] wr_data,
  output logic              core_run,
  output logic              boot_done,
  output logic              boot_src
);

  localparam logic [RAM_AW-1:0] LAST = RAM_AW'(RAM_BYTES - 1);

  boot_st_t          st;
  logic [RAM_AW-1:0] addr_q;
  logic              req_q, run_q, done_q, src_q;

  assign wr_en   = (st == ST_WAIT) && ext_rd_valid;
  assign wr_addr = addr_q;
  assign wr_data = ext_rd_data;

  always_ff @(posedge clk) begin
    if (rst) begin
      st     <= ST_SAMPLE;
      addr_q <= '0;
      req_q  <= 1'b0;
      run_q  <= 1'b0;
      done_q <= 1'b0;
      src_q  <= 1'b0;
    end else begin
      unique case (st)
        ST_SAMPLE: begin
          src_q  <= strap;
          addr_q <= '0;
          if (strap) begin
            st <= ST_ISSUE;
          end else begin
            st     <= ST_RUN;
            run_q  <= 1'b1;
            done_q <= 1'b1;
          end
        end
        ST_ISSUE: begin
          req_q <= 1'b1;
          st    <= ST_WAIT;
        end
        ST_WAIT: begin
          req_q <= 1'b0;
          if (ext_rd_valid) begin
            if (addr_q == LAST) begin
              st     <= ST_RUN;
              run_q  <= 1'b1;
              done_q <= 1'b1;
            end else begin
              addr_q <= addr_q + 1'b1;
              st     <= ST_ISSUE;
            end
          end
        end
        ST_RUN:  st <= ST_RUN;
        default: st <= ST_SAMPLE;
      endcase
    end
  end

  assign ext_rd_req  = req_q;
  assign ext_rd_addr = addr_q;
  assign core_run    = run_q;
  assign boot_done   = done_q;
  assign boot_src    = src_q;

  AST_REQ_WHILE_HALTED: assert property (@(posedge clk) disable iff (rst)
    ext_rd_req |-> !core_run);                                            // R4
  AST_RUN_AFTER_LAST: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_addr == LAST) |=> core_run);                              // R4
  AST_REQ_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    ext_rd_req |=> !ext_rd_req);                                           // R3
  AST_ADDR_STEP: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_addr != LAST) |=> (ext_rd_addr == $past(wr_addr) + 1'b1)); // R3
  AST_RUN_STICKY: assert property (@(posedge clk) disable iff (rst)
    core_run |=> core_run);                                                // R9
  AST_SRC_HOLD: assert property (@(posedge clk) disable iff (rst)
    boot_done |=> (boot_done && $stable(boot_src)));                       // R9
  AST_INT_NO_REQ: assert property (@(posedge clk) disable iff (rst)
    (boot_done && !boot_src) |-> !ext_rd_req);                             // R2

endmodule

// File: rtl/shadow_ram.sv
module shadow_ram
  import boot_pkg::*;
#(
  parameter int DEPTH = 1536,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              we,
  input  logic [AW-1:0]     waddr,
  input  logic [BYTE_W-1:0] wdata,
  input  logic [AW-1:0]     raddr,
  output logic [BYTE_W-1:0] rdata
);

  logic [BYTE_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end

endmodule

// File: rtl/code_rom.sv
module code_rom
  import boot_pkg::*;
#(
  parameter int DEPTH = 4096,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic [AW-1:0]     raddr,
  output logic [BYTE_W-1:0] rdata
);

  always_ff @(posedge clk) begin
    rdata <= rom_pattern(12'(raddr));
  end

endmodule

// File: rtl/boot_shadow_ctrl.sv
module boot_shadow_ctrl
  import boot_pkg::*;
#(
  parameter int RAM_BYTES = 1536,
  parameter int ROM_BYTES = 4096,
  parameter int RAM_AW    = $clog2(RAM_BYTES),
  parameter int ROM_AW    = $clog2(ROM_BYTES),
  parameter int FETCH_AW  = ROM_AW + 1
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                strap_ext_rom,
  output logic                ext_rd_req,
  output logic [RAM_AW-1:0]   ext_rd_addr,
  input  logic                ext_rd_valid,
  input  logic [BYTE_W-1:0]   ext_rd_data,
  input  logic [FETCH_AW-1:0] fetch_addr,
  output logic [BYTE_W-1:0]   fetch_data,
  output logic                core_run,
  output logic                boot_done,
  output logic                boot_src
);

  localparam logic [FETCH_AW-1:0] RAM_LIM = FETCH_AW'(RAM_BYTES);
  localparam logic [FETCH_AW-1:0] ROM_LIM = FETCH_AW'(ROM_BYTES);

  logic              wr_en;
  logic [RAM_AW-1:0] wr_addr;
  logic [BYTE_W-1:0] wr_data;
  logic [BYTE_W-1:0] ram_q, rom_q;
  logic              sel_ext_q, ok_q;
  logic              in_ram, in_rom;

  boot_copy_seq #(.RAM_BYTES(RAM_BYTES), .RAM_AW(RAM_AW)) u_seq (
    .clk         (clk),
    .rst         (rst),
    .strap       (strap_ext_rom),
    .ext_rd_req  (ext_rd_req),
    .ext_rd_addr (ext_rd_addr),
    .ext_rd_valid(ext_rd_valid),
    .ext_rd_data (ext_rd_data),
    .wr_en       (wr_en),
    .wr_addr     (wr_addr),
    .wr_data     (wr_data),
    .core_run    (core_run),
    .boot_done   (boot_done),
    .boot_src    (boot_src)
  );

  shadow_ram #(.DEPTH(RAM_BYTES), .AW(RAM_AW)) u_ram (
    .clk  (clk),
    .we   (wr_en),
    .waddr(wr_addr),
    .wdata(wr_data),
    .raddr(fetch_addr[RAM_AW-1:0]),
    .rdata(ram_q)
  );

  code_rom #(.DEPTH(ROM_BYTES), .AW(ROM_AW)) u_rom (
    .clk  (clk),
    .raddr(fetch_addr[ROM_AW-1:0]),
    .rdata(rom_q)
  );

  assign in_ram = fetch_addr < RAM_LIM;
  assign in_rom = fetch_addr < ROM_LIM;

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_ext_q <= 1'b0;
      ok_q      <= 1'b0;
    end else begin
      sel_ext_q <= boot_src;
      ok_q      <= core_run && (boot_src ? in_ram : in_rom);
    end
  end

  assign fetch_data = ok_q ? (sel_ext_q ? ram_q : rom_q) : '0;

  AST_HALTED_READS_ZERO: assert property (@(posedge clk) disable iff (rst)
    !$past(core_run) |-> (fetch_data == '0));                              // R8
  AST_OOR_READS_ZERO: assert property (@(posedge clk) disable iff (rst)
    ($past(core_run) && ($past(fetch_addr) >= ($past(boot_src) ? RAM_LIM : ROM_LIM)))
      |-> (fetch_data == '0));                                             // R7
  AST_EXT_FROM_RAM: assert property (@(posedge clk) disable iff (rst)
    $past(core_run && boot_src && (fetch_addr < RAM_LIM)) |-> (fetch_data == ram_q)); // R5

endmodule

// File: tb/tb_boot_shadow_ctrl.sv
module tb_boot_shadow_ctrl;

  localparam int NB = 1536;

  logic        clk = 1'b0;
  logic        rst;
  logic        strap_ext_rom;
  logic        ext_rd_req;
  logic [10:0] ext_rd_addr;
  logic        ext_rd_valid;
  logic [7:0]  ext_rd_data;
  logic [12:0] fetch_addr;
  logic [7:0]  fetch_data;
  logic        core_run, boot_done, boot_src;

  always #4 clk = ~clk;

  boot_shadow_ctrl dut (
    .clk(clk), .rst(rst), .strap_ext_rom(strap_ext_rom),
    .ext_rd_req(ext_rd_req), .ext_rd_addr(ext_rd_addr),
    .ext_rd_valid(ext_rd_valid), .ext_rd_data(ext_rd_data),
    .fetch_addr(fetch_addr), .fetch_data(fetch_data),
    .core_run(core_run), .boot_done(boot_done), .boot_src(boot_src)
  );

  int n_chk = 0;
  int n_fail = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int ext_byte(input int a);
    return (a & 8'hFF) ^ ((a >> 8) & 7) ^ 8'hC3;
  endfunction

  function automatic int rom_ref(input int a);
    return (a & 8'hFF) ^ (((a >> 8) & 15) * 17) ^ 8'h5A;
  endfunction

  // Scoreboard for fetches
  typedef struct { int exp; string tag; } fexp_t;
  fexp_t sbq[$];
  fexp_t cur;

  task automatic fetch(input int a, input int exp, input string tag);
    @(negedge clk);
    fetch_addr = 13'(a);
    sbq.push_back('{exp, tag});
  endtask

  always @(posedge clk) begin
    #2;
    if (sbq.size() > 0) begin
      cur = sbq.pop_front();
      chk(int'(fetch_data) == cur.exp, cur.tag, int'(fetch_data), cur.exp);
    end
  end

  // External ROM model
  int exp_addr = 0;
  int served = 0;
  int req_err = 0;
  int req_seen = 0;
  int last_lo = -1;
  int last_hi = -1;

  initial begin
    ext_rd_valid = 1'b0;
    ext_rd_data  = '0;
    forever begin
      @(negedge clk);
      if (rst) begin
        exp_addr = 0;
        served   = 0;
      end else if (ext_rd_req) begin
        int a;
        int lat;
        bit aborted;
        a = int'(ext_rd_addr);
        req_seen++;
        if (a != exp_addr) req_err++;
        lat = 1 + (a % 3);
        aborted = 1'b0;
        for (int i = 0; i < lat; i++) begin
          @(negedge clk);
          if (rst) aborted = 1'b1;
          if (ext_rd_req) req_err++;
        end
        if (aborted) begin
          exp_addr = 0;
          served   = 0;
        end else begin
          ext_rd_valid = 1'b1;
          ext_rd_data  = 8'(ext_byte(a));
          if (a == NB - 1) last_lo = int'(core_run);
          @(negedge clk);
          ext_rd_valid = 1'b0;
          if (a == NB - 1) last_hi = int'(core_run);
          served++;
          exp_addr = a + 1;
        end
      end
    end
  end

  task automatic do_reset(input bit s);
    @(negedge clk);
    rst = 1'b1;
    strap_ext_rom = s;
    repeat (4) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic wait_run();
    int g = 0;
    while (!core_run && g < 30000) begin
      @(negedge clk);
      g++;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    int seen0;
    rst = 1'b1;
    strap_ext_rom = 1'b0;
    fetch_addr = '0;
    repeat (3) @(negedge clk);
    chk(core_run == 1'b0, "R8 reset core_run", int'(core_run), 0);
    chk(boot_done == 1'b0, "R9 reset boot_done", int'(boot_done), 0);
    chk(ext_rd_req == 1'b0, "R2 reset req", int'(ext_rd_req), 0);
    chk(fetch_data == 8'h00, "R8 reset fetch", int'(fetch_data), 0);

    // Internal boot
    rst = 1'b0;
    @(negedge clk);
    chk(core_run == 1'b1, "R2 core_run after first edge", int'(core_run), 1);
    chk(boot_done == 1'b1, "R2 boot_done", int'(boot_done), 1);
    chk(boot_src == 1'b0, "R2 boot_src", int'(boot_src), 0);
    strap_ext_rom = 1'b1;
    repeat (5) @(negedge clk);
    chk(boot_src == 1'b0, "R1 strap change ignored", int'(boot_src), 0);
    chk(req_seen == 0, "R2 no request in internal mode", req_seen, 0);
    fetch(0, rom_ref(0), "R6 rom 0");
    fetch(1, rom_ref(1), "R6 rom 1");
    fetch(300, rom_ref(300), "R6 rom 300");
    fetch(1536, rom_ref(1536), "R6 rom 1536");
    fetch(4095, rom_ref(4095), "R6 rom 4095");
    fetch(4096, 0, "R7 int 4096");
    fetch(8191, 0, "R7 int 8191");
    fetch(2749, rom_ref(2749), "R1 rom after strap flip");
    repeat (2) @(negedge clk);

    // External boot aborted, reboot with strap low
    do_reset(1'b1);
    while (served < 40) @(negedge clk);
    fetch(5, 0, "R8 fetch during copy");
    do_reset(1'b0);
    seen0 = req_seen;
    @(negedge clk);
    chk(boot_src == 1'b0, "R10 fresh sample internal", int'(boot_src), 0);
    chk(core_run == 1'b1, "R10 internal run after abort", int'(core_run), 1);
    repeat (6) @(negedge clk);
    chk(req_seen == seen0, "R10 copy stays aborted", req_seen - seen0, 0);
    fetch(100, rom_ref(100), "R10 rom after abort");
    repeat (2) @(negedge clk);

    // External boot aborted, restarted with strap high, full copy
    do_reset(1'b1);
    while (served < 25) @(negedge clk);
    do_reset(1'b1);
    req_err = 0;
    seen0 = req_seen;
    fetch(0, 0, "R8 fetch while copying");
    wait_run();
    chk(req_err == 0, "R3/R10 request order and single pulse", req_err, 0);
    chk(req_seen - seen0 == NB, "R3 request count", req_seen - seen0, NB);
    chk(served == NB, "R10 restart served all bytes", served, NB);
    chk(last_lo == 0, "R4 core_run low at last valid", last_lo, 0);
    chk(last_hi == 1, "R4 core_run high after last write", last_hi, 1);
    chk(boot_src == 1'b1, "R9 boot_src external", int'(boot_src), 1);
    fetch(0, ext_byte(0), "R5 ram 0");
    fetch(1, ext_byte(1), "R5 ram 1");
    fetch(100, ext_byte(100), "R5 ram not rom 100");
    fetch(777, ext_byte(777), "R5 ram 777");
    fetch(1535, ext_byte(1535), "R5 ram 1535");
    fetch(1536, 0, "R7 ext 1536");
    fetch(4095, 0, "R7 ext 4095");
    fetch(6000, 0, "R7 ext 6000");
    strap_ext_rom = 1'b0;
    repeat (4) @(negedge clk);
    chk(boot_src == 1'b1, "R9 src held", int'(boot_src), 1);
    chk(boot_done == 1'b1, "R9 done held", int'(boot_done), 1);
    chk(core_run == 1'b1, "R1 run held", int'(core_run), 1);
    fetch(200, ext_byte(200), "R1 ram after strap flip");
    repeat (3) @(negedge clk);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule